// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This block manages a small pool of equal-sized packet buffers for a network controller. A bitmap records which buffers are in use, and a new allocation always takes the lowest-numbered free buffer. Host software drives the unit with a command byte whose top three bits select the operation. The bottom five bits are ignored. A separate input holds a packet number, which the release and enqueue commands use.

The unit keeps three short queues of buffer numbers. The transmit queue holds packets waiting to be sent. The completion queue holds packets whose transmission has finished. The receive queue holds buffers filled by incoming frames. Two more inputs feed the queues: the transmitter signals completion of the transmit head, and the receiver asks for a buffer for each new frame. An eight-bit interrupt status register is combined with a mask register to drive a single interrupt line. The block does not move packet data and does not perform the physical transmit.

Top module: `pkt_pool_mgr`

## Requirements
- R1: Every allocation takes the lowest-numbered free buffer and marks it in `buf_map` (bit i set means buffer i is in use). When all buffers are in use, a transmit allocation gives the result 0x80.
- R2: `cmd_byte[7:5]` selects the command: 0 no-op, 1 transmit allocate, 2 unit reset, 3 drop receive head, 4 drop receive head and free its buffer, 5 free buffer `pkt_sel`, 6 queue `pkt_sel` for transmit, 7 empty the transmit and completion queues. Bits [4:0] have no effect.
- R3: Command 1 first sets the result to 0x80 and clears status bit 3 (allocation done). If a buffer is then obtained, the result becomes its number and bit 3 is set.
- R4: Freeing a buffer while the result is 0x80 repeats the transmit allocation in the same cycle. Freeing a buffer while the result holds a number leaves the result unchanged.
- R5: `tx_head`, `done_head` and `rx_head` show the number at the head of their queue, or 0x80 when that queue is empty.
- R6: Dropping the receive head shifts the receive queue forward. Status bit 0 (receive) stays set while entries remain and clears when the queue empties. Command 4 also frees the dropped buffer. Dropping from an empty queue changes nothing else.
- R7: Status bit 2 (transmit empty) is set in every cycle where the transmit queue ends empty. Status bit 1 (transmit done) is set in every cycle where the completion queue ends non-empty.
- R8: `irq` is high exactly when status AND mask is non-zero. `mask_we` loads `mask_in` into the mask.
- R9: An acknowledge clears the status bits that are set in `ack_byte & 8'hD6`. If `ack_byte[1]` is set, the acknowledge also removes one entry from the completion queue.
- R10: After `rst_n`, status is 0x04, the mask is 0, the result is 0 and all queues and the bitmap are empty. Command 2 empties the bitmap and all three queues and sets the result to 0.
- R11: Adding to a queue that already holds NBUF entries is ignored. A receive request is refused when no buffer is free or the receive queue is full, and `rx_ready` shows whether a request would be accepted.
- R12: A `tx_done` pulse moves the transmit head to the tail of the completion queue. The pulse is ignored when the transmit queue is empty.
- R13: All events presented in one cycle take effect together at the next clock edge, applied in this order: command, `tx_done`, `rx_req`, acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command byte, opcode in [7:5] |
| pkt_sel | input | IW | Packet number used by commands 5 and 6 |
| tx_done | input | 1 | Transmit head has been sent |
| rx_req | input | 1 | Receiver asks for a buffer |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_byte | input | 8 | Status bits to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_in | input | 8 | New mask value |
| alloc_result | output | 8 | Last transmit allocation, 0x80 if pending |
| buf_map | output | NBUF | Allocation bitmap |
| tx_head | output | 8 | Transmit queue head or 0x80 |
| done_head | output | 8 | Completion queue head or 0x80 |
| rx_head | output | 8 | Receive queue head or 0x80 |
| status | output | 8 | Interrupt status |
| mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |
| rx_ready | output | 1 | A receive request would be accepted now |

## Verification
The assertions check, on every cycle, that the status bits agree with queue occupancy: transmit-empty whenever the transmit head reads 0x80, transmit-done whenever the completion head holds a number, and receive whenever the receive head holds a number. They also check that a transmit allocate always gives 0x80 from a full pool, that an accepted receive request adds exactly one bit to the bitmap, and that the reset command empties everything. Only the bench scenarios can show the sequences: the lowest-free order, the automatic retry after a release, the queue contents in FIFO order, enqueues that are ignored on a full queue, and the ordering of events that arrive in the same cycle.

// File: rtl/pkt_pool_mgr.sv
module pkt_pool_mgr #(
  parameter int NBUF = 4,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_byte,
  input  logic [IW-1:0]   pkt_sel,
  input  logic            tx_done,
  input  logic            rx_req,
  input  logic            ack_valid,
  input  logic [7:0]      ack_byte,
  input  logic            mask_we,
  input  logic [7:0]      mask_in,
  output logic [7:0]      alloc_result,
  output logic [NBUF-1:0] buf_map,
  output logic [7:0]      tx_head,
  output logic [7:0]      done_head,
  output logic [7:0]      rx_head,
  output logic [7:0]      status,
  output logic [7:0]      mask,
  output logic            irq,
  output logic            rx_ready
);

  localparam int CW = $clog2(NBUF + 1);
  localparam logic [7:0] NONE = 8'h80;
  localparam logic [CW-1:0] FULL = CW'(NBUF);

  typedef logic [NBUF-1:0][IW-1:0] q_t;

  q_t txq, dnq, rxq, n_txq, n_dnq, n_rxq;
  logic [CW-1:0] txn, dnn, rxn, n_txn, n_dnn, n_rxn;
  logic [NBUF-1:0] busy, n_busy;
  logic [7:0] alloc_r, n_alloc, stat, n_stat, mask_r;
  logic [2:0] op;
  logic rel_en, retry, pop_rx;
  logic [IW-1:0] rel_idx, head;
  logic [IW:0] pick;
  logic unused_low;

  assign op = cmd_byte[7:5];
  assign unused_low = ^cmd_byte[4:0];

  function automatic logic [IW:0] lowest_free(input logic [NBUF-1:0] b);
    logic [IW:0] r;
    r = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (!b[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  always_comb begin
    n_busy = busy;  n_alloc = alloc_r;  n_stat = stat;
    n_txq = txq;    n_dnq = dnq;        n_rxq = rxq;
    n_txn = txn;    n_dnn = dnn;        n_rxn = rxn;
    rel_en = 1'b0;  rel_idx = '0;  retry = 1'b0;  pop_rx = 1'b0;
    pick = '0;      head = '0;

    if (cmd_valid) begin
      case (op)
        3'd1: begin n_alloc = NONE; n_stat[3] = 1'b0; retry = 1'b1; end
        3'd2: begin
          n_busy = '0; n_txn = '0; n_dnn = '0; n_rxn = '0; n_alloc = '0;
        end
        3'd3: pop_rx = 1'b1;
        3'd4: begin
          if (rxn != '0) begin rel_en = 1'b1; rel_idx = rxq[0]; end
          pop_rx = 1'b1;
        end
        3'd5: if (int'(pkt_sel) < NBUF) begin rel_en = 1'b1; rel_idx = pkt_sel; end
        3'd6: if (txn < FULL) begin
          n_txq[txn[IW-1:0]] = pkt_sel;
          n_txn = txn + 1'b1;
        end
        3'd7: begin n_txn = '0; n_dnn = '0; end
        default: ;
      endcase
    end

    if (pop_rx) begin
      if (n_rxn != '0) begin
        n_rxq = n_rxq >> IW;
        n_rxn = n_rxn - 1'b1;
      end
      n_stat[0] = (n_rxn != '0);
    end

    if (rel_en) begin
      n_busy[rel_idx] = 1'b0;
      if (n_alloc == NONE) retry = 1'b1;
    end

    if (retry) begin
      pick = lowest_free(n_busy);
      if (pick[IW]) begin
        n_busy[pick[IW-1:0]] = 1'b1;
        n_alloc = 8'(pick[IW-1:0]);
        n_stat[3] = 1'b1;
      end
    end

    if (tx_done && n_txn != '0) begin
      head = n_txq[0];
      n_txq = n_txq >> IW;
      n_txn = n_txn - 1'b1;
      if (n_dnn < FULL) begin
        n_dnq[n_dnn[IW-1:0]] = head;
        n_dnn = n_dnn + 1'b1;
      end
    end

    if (rx_req) begin
      pick = lowest_free(n_busy);
      if (pick[IW] && n_rxn < FULL) begin
        n_busy[pick[IW-1:0]] = 1'b1;
        n_rxq[n_rxn[IW-1:0]] = pick[IW-1:0];
        n_rxn = n_rxn + 1'b1;
        n_stat[0] = 1'b1;
      end
    end

    if (ack_valid) begin
      n_stat = n_stat & ~(ack_byte & 8'hD6);
      if (ack_byte[1] && n_dnn != '0) begin
        n_dnq = n_dnq >> IW;
        n_dnn = n_dnn - 1'b1;
      end
    end

    if (n_txn == '0) n_stat[2] = 1'b1;
    if (n_dnn != '0) n_stat[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;  alloc_r <= '0;  stat <= 8'h04;  mask_r <= '0;
      txq <= '0;   dnq <= '0;      rxq <= '0;
      txn <= '0;   dnn <= '0;      rxn <= '0;
    end else begin
      busy <= n_busy;  alloc_r <= n_alloc;  stat <= n_stat;
      txq <= n_txq;    dnq <= n_dnq;        rxq <= n_rxq;
      txn <= n_txn;    dnn <= n_dnn;        rxn <= n_rxn;
      if (mask_we) mask_r <= mask_in;
    end
  end

  assign alloc_result = alloc_r;
  assign buf_map      = busy;
  assign tx_head      = (txn == '0) ? NONE : 8'(txq[0]);
  assign done_head    = (dnn == '0) ? NONE : 8'(dnq[0]);
  assign rx_head      = (rxn == '0) ? NONE : 8'(rxq[0]);
  assign status       = stat;
  assign mask         = mask_r;
  assign irq          = |(stat & mask_r);
  assign rx_ready     = ~&busy && (rxn < FULL);

endmodule

module pkt_pool_mgr_chk #(
  parameter int NBUF = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [7:0]      cmd_byte,
  input logic            rx_req,
  input logic [7:0]      alloc_result,
  input logic [NBUF-1:0] buf_map,
  input logic [7:0]      tx_head,
  input logic [7:0]      done_head,
  input logic [7:0]      rx_head,
  input logic [7:0]      status,
  input logic            rx_ready
);

  // R1
  full_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd1 && &buf_map) |=> alloc_result == 8'h80);

  // R3
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd1 && !(&buf_map)) |=> (alloc_result != 8'h80 && status[3]));

  // R7
  tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_head == 8'h80 |-> status[2]);

  // R7
  tx_done_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_head != 8'h80 |-> status[1]);

  // R6
  rcv_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_head != 8'h80 |-> status[0]);

  // R11
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_ready && !cmd_valid) |=> $countones(buf_map) == $countones($past(buf_map)) + 1);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd2 && !rx_req) |=>
      (buf_map == '0 && alloc_result == 8'h00 && rx_head == 8'h80 && tx_head == 8'h80 && done_head == 8'h80));

endmodule

bind pkt_pool_mgr pkt_pool_mgr_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .rx_req(rx_req), .alloc_result(alloc_result), .buf_map(buf_map),
  .tx_head(tx_head), .done_head(done_head), .rx_head(rx_head),
  .status(status), .rx_ready(rx_ready)
);

// File: tb/test_pkt_pool_mgr.sv
module test_pkt_pool_mgr;
  localparam int PERIOD = 10;
  localparam int NB = 4;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, tx_done = 0, rx_req = 0, ack_valid = 0, mask_we = 0;
  logic [7:0] cmd_byte = '0, ack_byte = '0, mask_in = '0;
  logic [SW-1:0] pkt_sel = '0;
  logic [7:0] alloc_result, tx_head, done_head, rx_head, status, mask;
  logic [NB-1:0] buf_map;
  logic irq, rx_ready;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  pkt_pool_mgr #(.NBUF(NB)) i_pkt_pool_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .pkt_sel(pkt_sel), .tx_done(tx_done), .rx_req(rx_req), .ack_valid(ack_valid),
    .ack_byte(ack_byte), .mask_we(mask_we), .mask_in(mask_in),
    .alloc_result(alloc_result), .buf_map(buf_map), .tx_head(tx_head),
    .done_head(done_head), .rx_head(rx_head), .status(status), .mask(mask),
    .irq(irq), .rx_ready(rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic cv, input logic [7:0] cb, input logic [SW-1:0] sel,
                      input logic td, input logic rr, input logic av, input logic [7:0] ab);
    cmd_valid = cv; cmd_byte = cb; pkt_sel = sel;
    tx_done = td; rx_req = rr; ack_valid = av; ack_byte = ab;
    @(negedge clk);
    cmd_valid = 0; tx_done = 0; rx_req = 0; ack_valid = 0;
  endtask

  task automatic cmd(input logic [7:0] b, input logic [SW-1:0] sel);
    step(1, b, sel, 0, 0, 0, 8'h00);
  endtask
  task automatic done_pulse();   step(0, 8'h00, '0, 1, 0, 0, 8'h00); endtask
  task automatic rx_pulse();     step(0, 8'h00, '0, 0, 1, 0, 8'h00); endtask
  task automatic ack(input logic [7:0] b); step(0, 8'h00, '0, 0, 0, 1, b); endtask
  task automatic set_mask(input logic [7:0] m);
    mask_we = 1; mask_in = m; @(negedge clk); mask_we = 0;
  endtask

  task automatic t_reset_state();
    chk("R10 status", status, 8'h04);
    chk("R10 mask", mask, 8'h00);
    chk("R10 result", alloc_result, 8'h00);
    chk("R10 bitmap", buf_map, 4'b0000);
    chk("R5 tx empty", tx_head, 8'h80);
    chk("R5 done empty", done_head, 8'h80);
    chk("R5 rx empty", rx_head, 8'h80);
    chk("R8 irq idle", irq, 1'b0);
  endtask

  task automatic t_alloc_and_retry();
    cmd(8'h20, 0);
    chk("R1 first", alloc_result, 8'h00);
    chk("R3 status", status, 8'h0C);
    cmd(8'h3F, 0);
    chk("R2 low bits ignored", alloc_result, 8'h01);
    chk("R1 bitmap", buf_map, 4'b0011);
    ack(8'hFF);
    chk("R9 D6 mask", status, 8'h0C);
    cmd(8'h20, 0); cmd(8'h20, 0);
    chk("R1 fourth", alloc_result, 8'h03);
    cmd(8'h20, 0);
    chk("R1 full result", alloc_result, 8'h80);
    chk("R3 bit cleared", status, 8'h04);
    cmd(8'hA2, 2'd2);
    chk("R4 retry result", alloc_result, 8'h02);
    chk("R4 retry bitmap", buf_map, 4'b1111);
    chk("R4 retry status", status, 8'h0C);
    cmd(8'hA0, 2'd3);
    chk("R4 no retry result", alloc_result, 8'h02);
    chk("R4 no retry bitmap", buf_map, 4'b0111);
  endtask

  task automatic t_tx_path();
    cmd(8'h40, 0);
    chk("R10 cmd bitmap", buf_map, 4'b0000);
    chk("R10 cmd result", alloc_result, 8'h00);
    cmd(8'h20, 0);
    cmd(8'hC0, 2'd0);
    chk("R5 tx head", tx_head, 8'h00);
    ack(8'h04);
    chk("R7 txempty cleared", status[2], 1'b0);
    done_pulse();
    chk("R12 tx emptied", tx_head, 8'h80);
    chk("R12 done head", done_head, 8'h00);
    chk("R7 tx bits", status[2:1], 2'b11);
    set_mask(8'h02);
    chk("R8 mask reg", mask, 8'h02);
    chk("R8 irq high", irq, 1'b1);
    ack(8'h02);
    chk("R9 done popped", done_head, 8'h80);
    chk("R9 tx bit clear", status[1], 1'b0);
    chk("R8 irq low", irq, 1'b0);
  endtask

  task automatic t_tx_full();
    cmd(8'h40, 0);
    for (int i = 0; i < NB; i++) cmd(8'hC0, SW'(i));
    cmd(8'hC0, 2'd3);
    for (int i = 0; i < NB; i++) done_pulse();
    chk("R11 fifth enqueue ignored", tx_head, 8'h80);
    done_pulse();
    chk("R12 ignored on empty", done_head, 8'h00);
    for (int i = 1; i < NB; i++) begin
      ack(8'h02);
      chk("R9 done order", done_head, 32'(i));
    end
    ack(8'h02);
    chk("R11 done length", done_head, 8'h80);
    cmd(8'hC0, 2'd1); done_pulse(); cmd(8'hC0, 2'd2);
    chk("R2 setup tx", tx_head, 8'h02);
    cmd(8'hE0, 0);
    chk("R2 cmd7 tx", tx_head, 8'h80);
    chk("R2 cmd7 done", done_head, 8'h80);
  endtask

  task automatic t_rx_path();
    cmd(8'h40, 0);
    rx_pulse(); rx_pulse();
    chk("R1 rx head", rx_head, 8'h00);
    chk("R1 rx bitmap", buf_map, 4'b0011);
    chk("R6 rcv set", status[0], 1'b1);
    set_mask(8'h01);
    chk("R8 rcv irq", irq, 1'b1);
    cmd(8'h60, 0);
    chk("R6 shifted", rx_head, 8'h01);
    chk("R6 rcv kept", status[0], 1'b1);
    chk("R6 no free", buf_map, 4'b0011);
    cmd(8'h80, 0);
    chk("R6 emptied", rx_head, 8'h80);
    chk("R6 rcv cleared", status[0], 1'b0);
    chk("R6 freed", buf_map, 4'b0001);
    cmd(8'h60, 0);
    chk("R6 empty pop", buf_map, 4'b0001);
    set_mask(8'h00);
    chk("R8 mask off", irq, 1'b0);
  endtask

  task automatic t_rx_full();
    cmd(8'h40, 0);
    chk("R11 ready", rx_ready, 1'b1);
    for (int i = 0; i < NB; i++) rx_pulse();
    chk("R11 not ready", rx_ready, 1'b0);
    rx_pulse();
    chk("R11 bitmap full", buf_map, 4'b1111);
    cmd(8'h80, 0);
    chk("R6 head after free", rx_head, 8'h01);
    chk("R6 bitmap after free", buf_map, 4'b1110);
    chk("R11 ready again", rx_ready, 1'b1);
  endtask

  task automatic t_same_cycle();
    cmd(8'h40, 0);
    cmd(8'h20, 0);
    step(1, 8'h20, '0, 0, 1, 0, 8'h00);
    chk("R13 cmd first", alloc_result, 8'h01);
    chk("R13 rx second", rx_head, 8'h02);
    chk("R13 bitmap", buf_map, 4'b0111);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_alloc_and_retry();
    t_tx_path();
    t_tx_full();
    t_rx_path();
    t_rx_full();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule